// File: doc/BRIEF.md
# Unipolar Bridge PWM Modulator

This block converts a signed digital audio sample into two pulse-width drive signals, P and N, one for each half of a bridge-tied load. It uses a three-level (unipolar) scheme. P is produced by comparing a triangle carrier with +sample, and N by comparing the same carrier with -sample. As a result, the load difference P-N rests at zero and pulses toward one rail only: positive for positive samples, negative for negative samples. At zero input both outputs carry the same square wave, and the load sees pulses at twice the carrier rate.

The carrier is an up/down counter whose half-scale `amp_i` sets the switching period. In master mode the counter runs freely and drives a sync square wave out at twice the switching rate. In slave mode the carrier is re-started from an external sync input, which gives a switching rate of half the sync rate. A collision guard stops P and N from ever changing on the same clock edge. The sample and the half-scale are picked up only at the carrier peak. Each output has an active-low enable flag for the driver, so both can be put into high impedance.

Top module: `ubpwm_mod`

## Requirements
- R1: While `rst_ni` is low, `p_o`, `n_o` and `sync_o` are 0.
- R2: With half-scale M = `amp_i` (two's-complement sample s), one carrier period is 4*M clock cycles. In that period `p_o` is high for 2*clamp(s+M, 0, 2M) cycles and `n_o` is high for 2*clamp(M-s, 0, 2M) cycles.
- R3: Once settled with s > 0, there is never a cycle with `p_o`=0 and `n_o`=1. With s < 0, there is never a cycle with `p_o`=1 and `n_o`=0. The difference never steps directly from +1 to -1 or back.
- R4: At s = 0, both outputs are 50% square waves. `n_o` repeats each edge of `p_o` exactly STAGGER clock cycles later (default 2).
- R5: `p_o` and `n_o` never change on the same clock edge. When both compare results change together, P moves first and N is held for STAGGER cycles.
- R6: `sample_i` and `amp_i` are captured only at the carrier peak. A sample change in mid-period has no effect on the outputs until after the next peak.
- R7: When |s| >= M, one output is high for the whole period and the other is low for the whole period.
- R8: With `master_i`=1, `sync_oe_o`=1 and `sync_o` is a square wave with a period of 2*M cycles, which is twice the carrier rate.
- R9: With `master_i`=0, `sync_oe_o`=0 and `sync_o`=0. `sync_i` passes through a two-flop synchronizer, and every second rising edge restarts the carrier at its valley. When the sync period is at most 2*M cycles, the switching period is therefore twice the sync period.
- R10: With `out_en_i`=0, `p_oe_no`=`n_oe_no`=1 (high impedance) and `p_o`=`n_o`=0. With `out_en_i`=1, both enable flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | SMP_W | Signed audio sample |
| amp_i | input | AMP_W | Carrier half-scale M, sets period 4*M |
| master_i | input | 1 | 1: free-running master, 0: slave to sync_i |
| sync_i | input | 1 | External sync (slave mode) |
| sync_o | output | 1 | Sync square wave at twice the carrier rate (master) |
| sync_oe_o | output | 1 | Drive enable for the sync pin |
| out_en_i | input | 1 | Output enable |
| p_o | output | 1 | Positive-half PWM drive |
| n_o | output | 1 | Negative-half PWM drive |
| p_oe_no | output | 1 | Active-low drive enable for P |
| n_oe_no | output | 1 | Active-low drive enable for N |

## Verification
The bench targets the zero-input case. If the stagger were missing, P and N would switch on the same edge; if it had an off-by-one counter, the lag would be wrong. It also drives a sample that jumps mid-period: a design that compared against the live input would move P within two cycles instead of waiting for the peak. Saturated samples at and beyond the half-scale check that the thresholds clamp to a constant level and do not wrap. Slave runs with a short sync period check that the carrier restarts on every second sync edge; restarting on every edge would halve the measured period.

// File: rtl/ubpwm_pkg.sv
package ubpwm_pkg;
  typedef enum logic {RAMP_UP = 1'b0, RAMP_DN = 1'b1} ramp_e;
endpackage

// File: rtl/ubpwm_carrier.sv
module ubpwm_carrier
  import ubpwm_pkg::*;
#(
  parameter int AMP_W   = 8,
  parameter int AMP_RST = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AMP_W-1:0] amp_i,
  input  logic             master_i,
  input  logic             sync_i,
  output logic [AMP_W:0]   level_o,
  output logic [AMP_W-1:0] half_o,
  output logic             peak_o,
  output logic             sync_o
);
  localparam int KW = AMP_W + 1;

  logic [KW-1:0]    lvl_q, top;
  logic [AMP_W-1:0] half_q;
  ramp_e            dir_q;
  logic [2:0]       sy_q;
  logic             par_q, sync_q;
  logic             sy_rise, restart, at_top;

  assign top     = {half_q, 1'b0} - KW'(1);
  assign sy_rise = sy_q[1] & ~sy_q[2];
  // slave: every second synchronized rising edge restarts at the valley
  assign restart = ~master_i & sy_rise & par_q;
  assign at_top  = (dir_q == RAMP_UP) && (lvl_q >= top);
  assign peak_o  = at_top & ~restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_q   <= '0;
      par_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      sy_q   <= {sy_q[1:0], sync_i};
      par_q  <= master_i ? 1'b0 : (sy_rise ? ~par_q : par_q);
      sync_q <= master_i & ((lvl_q < {1'b0, half_q}) == (dir_q == RAMP_UP));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      dir_q  <= RAMP_UP;
      half_q <= AMP_W'(AMP_RST);
    end else if (restart) begin
      lvl_q <= '0;
      dir_q <= RAMP_UP;
    end else if (dir_q == RAMP_UP) begin
      if (at_top) begin
        dir_q  <= RAMP_DN;
        half_q <= (amp_i == '0) ? AMP_W'(1) : amp_i;
      end else begin
        lvl_q <= lvl_q + KW'(1);
      end
    end else begin
      if (lvl_q == '0) dir_q <= RAMP_UP;
      else             lvl_q <= lvl_q - KW'(1);
    end
  end

  assign level_o = lvl_q;
  assign half_o  = half_q;
  assign sync_o  = sync_q;
endmodule

// File: rtl/ubpwm_cmp.sv
module ubpwm_cmp #(
  parameter int SMP_W = 16,
  parameter int AMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [AMP_W:0]   level_i,
  input  logic [AMP_W-1:0] half_i,
  input  logic             peak_i,
  output logic [SMP_W-1:0] smp_o,
  output logic             p_o,
  output logic             n_o
);
  localparam int TW = ((SMP_W > AMP_W + 1) ? SMP_W : AMP_W + 1) + 2;

  logic [SMP_W-1:0]     smp_q;
  logic                 p_q, n_q;
  logic signed [TW-1:0] s_x, h_x, l_x, thr_p, thr_n;

  assign s_x   = {{(TW-SMP_W){smp_q[SMP_W-1]}}, smp_q};
  assign h_x   = {{(TW-AMP_W){1'b0}}, half_i};
  assign l_x   = {{(TW-AMP_W-1){1'b0}}, level_i};
  assign thr_p = h_x + s_x;
  assign thr_n = h_x - s_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      p_q   <= 1'b0;
      n_q   <= 1'b0;
    end else begin
      if (peak_i) smp_q <= sample_i;
      p_q <= (l_x < thr_p);
      n_q <= (l_x < thr_n);
    end
  end

  assign smp_o = smp_q;
  assign p_o   = p_q;
  assign n_o   = n_q;
endmodule

// File: rtl/ubpwm_stagger.sv
module ubpwm_stagger #(
  parameter int STAGGER = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic p_i,
  input  logic n_i,
  output logic p_o,
  output logic n_o
);
  localparam int HW = (STAGGER < 2) ? 1 : $clog2(STAGGER + 1);

  logic          p_q, n_q;
  logic [HW-1:0] hold_q;
  logic          p_tog;

  assign p_tog = p_i ^ p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q    <= 1'b0;
      n_q    <= 1'b0;
      hold_q <= '0;
    end else begin
      p_q <= p_i;
      if (hold_q != '0) begin
        hold_q <= hold_q - HW'(1);
      end else if (n_i != n_q) begin
        // P owns this edge; N waits STAGGER cycles in total
        if (p_tog) hold_q <= HW'(STAGGER - 1);
        else       n_q    <= n_i;
      end
    end
  end

  assign p_o = p_q;
  assign n_o = n_q;
endmodule

// File: rtl/ubpwm_mod.sv
module ubpwm_mod #(
  parameter int SMP_W   = 16,
  parameter int AMP_W   = 8,
  parameter int AMP_RST = 40,
  parameter int STAGGER = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic             master_i,
  input  logic             sync_i,
  output logic             sync_o,
  output logic             sync_oe_o,
  input  logic             out_en_i,
  output logic             p_o,
  output logic             n_o,
  output logic             p_oe_no,
  output logic             n_oe_no
);
  logic [AMP_W:0]   level;
  logic [AMP_W-1:0] half;
  logic             peak;
  logic [SMP_W-1:0] smp_hold;
  logic             p_cmp, n_cmp, p_drv, n_drv;

  ubpwm_carrier #(.AMP_W(AMP_W), .AMP_RST(AMP_RST)) u_carrier (
    .clk_i(clk_i), .rst_ni(rst_ni), .amp_i(amp_i), .master_i(master_i),
    .sync_i(sync_i), .level_o(level), .half_o(half), .peak_o(peak),
    .sync_o(sync_o)
  );

  ubpwm_cmp #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .level_i(level),
    .half_i(half), .peak_i(peak), .smp_o(smp_hold), .p_o(p_cmp), .n_o(n_cmp)
  );

  ubpwm_stagger #(.STAGGER(STAGGER)) u_stagger (
    .clk_i(clk_i), .rst_ni(rst_ni), .p_i(p_cmp), .n_i(n_cmp),
    .p_o(p_drv), .n_o(n_drv)
  );

  assign sync_oe_o = master_i;
  assign p_o       = out_en_i & p_drv;
  assign n_o       = out_en_i & n_drv;
  assign p_oe_no   = ~out_en_i;
  assign n_oe_no   = ~out_en_i;
endmodule

// File: rtl/ubpwm_chk.sv
module ubpwm_chk #(
  parameter int SMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             p_drv,
  input logic             n_drv,
  input logic             peak,
  input logic [SMP_W-1:0] smp_hold,
  input logic             master_i,
  input logic             sync_o
);
  AST_SPLIT_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(p_drv) |-> $stable(n_drv)); // R5

  AST_NO_SWAP_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(p_drv && !n_drv) |-> !(!p_drv && n_drv)); // R3

  AST_NO_SWAP_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!p_drv && n_drv) |-> !(p_drv && !n_drv)); // R3

  AST_SAMPLE_AT_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(peak) |-> $stable(smp_hold)); // R6

  AST_SLAVE_SYNC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!master_i) |-> !sync_o); // R9
endmodule

bind ubpwm_mod ubpwm_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .p_drv(p_drv), .n_drv(n_drv),
  .peak(peak), .smp_hold(smp_hold), .master_i(master_i), .sync_o(sync_o)
);

// File: tb/ubpwm_mod_bench.sv
`timescale 1ns/1ps
module ubpwm_mod_bench;
  localparam int SMP_W = 16;
  localparam int AMP_W = 8;
  localparam int STG   = 2;
  localparam int NV    = 12;
  localparam int VS [NV] = '{0, 3, -3, 8, -8, 100, -100, 1, -7, 2, -4, 0};
  localparam int VA [NV] = '{8, 8, 8, 8, 8, 8, 8, 8, 8, 5, 5, 5};

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [SMP_W-1:0] sample_i;
  logic [AMP_W-1:0] amp_i;
  logic             master_i, sync_i, out_en_i;
  logic             sync_o, sync_oe_o, p_o, n_o, p_oe_no, n_oe_no;
  logic             sync_en;
  int               checks = 0;
  int               fails  = 0;

  always #10 clk_i = ~clk_i;

  ubpwm_mod #(.SMP_W(SMP_W), .AMP_W(AMP_W), .STAGGER(STG)) u_ubpwm_mod (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .amp_i(amp_i),
    .master_i(master_i), .sync_i(sync_i), .sync_o(sync_o),
    .sync_oe_o(sync_oe_o), .out_en_i(out_en_i), .p_o(p_o), .n_o(n_o),
    .p_oe_no(p_oe_no), .n_oe_no(n_oe_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    return (w == 0) ? p_o : sync_o;
  endfunction

  task automatic rise_gap(input int w, output int gap);
    logic prev, cur;
    int   t, seen;
    prev = pick(w); gap = -1; t = 0; seen = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk_i);
      cur = pick(w);
      if (!prev && cur) begin
        if (seen == 0) begin seen = 1; t = 0; end
        else begin gap = t; break; end
      end
      t++;
      prev = cur;
    end
  endtask

  task automatic count_window(input int len, input int sgn,
                              output int pc, output int nc, output int bad);
    pc = 0; nc = 0; bad = 0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk_i);
      if (p_o) pc++;
      if (n_o) nc++;
      if (sgn > 0 && !p_o && n_o) bad++;
      if (sgn < 0 && p_o && !n_o) bad++;
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  // sync source: toggles every 3 cycles when enabled
  initial begin
    int sc;
    sc = 0;
    sync_i = 1'b0;
    forever begin
      @(negedge clk_i);
      if (sync_en) begin
        sc++;
        if (sc == 3) begin sc = 0; sync_i = ~sync_i; end
      end
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pc, nc, bad, ep, en, gap, d;
    logic prev, hi_seen;
    rst_ni = 1'b0; sample_i = '0; amp_i = 8'd8; master_i = 1'b1;
    out_en_i = 1'b1; sync_en = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!p_o && !n_o && !sync_o, "R1 reset outputs", {p_o, n_o, sync_o}, 0);
    rst_ni = 1'b1;

    // vector table: duty, unipolar, saturation
    for (int i = 0; i < NV; i++) begin
      sample_i = SMP_W'(VS[i]);
      amp_i    = AMP_W'(VA[i]);
      repeat (400) @(negedge clk_i);
      count_window(4 * VA[i], VS[i], pc, nc, bad);
      ep = 2 * clampi(VS[i] + VA[i], 2 * VA[i]);
      en = 2 * clampi(VA[i] - VS[i], 2 * VA[i]);
      if (VS[i] >= VA[i] || VS[i] <= -VA[i]) begin
        chk(pc == ep, "R7 saturated P count", pc, ep);
        chk(nc == en, "R7 saturated N count", nc, en);
      end else begin
        chk(pc == ep, "R2 P high count", pc, ep);
        chk(nc == en, "R2 N high count", nc, en);
      end
      if (VS[i] != 0) chk(bad == 0, "R3 wrong-polarity cycles", bad, 0);
    end

    // R4: zero input, N lags P by STG
    sample_i = '0; amp_i = 8'd8;
    repeat (400) @(negedge clk_i);
    prev = p_o;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i);
      if (!prev && p_o) break;
      prev = p_o;
    end
    d = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk_i); d++;
      if (n_o) break;
    end
    chk(d == STG, "R4 N rise lag", d, STG);
    prev = p_o;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i);
      if (prev && !p_o) break;
      prev = p_o;
    end
    d = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk_i); d++;
      if (!n_o) break;
    end
    chk(d == STG, "R4 N fall lag", d, STG);

    // R6: mid-period sample change held until the peak
    repeat (100) @(negedge clk_i);
    prev = p_o;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i);
      if (prev && !p_o) break;
      prev = p_o;
    end
    sample_i = SMP_W'(8);
    hi_seen = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk_i);
      if (p_o) hi_seen = 1'b1;
    end
    chk(!hi_seen, "R6 P unchanged before peak", hi_seen, 0);
    repeat (7) @(negedge clk_i);
    chk(p_o, "R6 P follows sample after peak", p_o, 1);

    // R8: master sync rate
    sample_i = '0;
    repeat (200) @(negedge clk_i);
    chk(sync_oe_o, "R8 sync drive enabled", sync_oe_o, 1);
    rise_gap(1, gap);
    chk(gap == 16, "R8 sync period", gap, 16);
    rise_gap(0, gap);
    chk(gap == 32, "R8 carrier period", gap, 32);

    // R9: slave, sync period 6 -> switching period 12
    master_i = 1'b0; sync_en = 1'b1;
    repeat (200) @(negedge clk_i);
    chk(!sync_oe_o && !sync_o, "R9 sync pin released", {sync_oe_o, sync_o}, 0);
    rise_gap(0, gap);
    chk(gap == 12, "R9 slave switching period", gap, 12);

    // R10: output enable
    out_en_i = 1'b0;
    @(negedge clk_i);
    chk(p_oe_no && n_oe_no, "R10 high-Z flags", {p_oe_no, n_oe_no}, 3);
    chk(!p_o && !n_o, "R10 outputs low when disabled", {p_o, n_o}, 0);
    out_en_i = 1'b1;
    @(negedge clk_i);
    chk(!p_oe_no && !n_oe_no, "R10 drive flags on", {p_oe_no, n_oe_no}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule